// File: doc/BRIEF.md
# Sprite List Buffer Copy Engine

This block holds the sprite attribute memory of a video subsystem: 128 entries of 16 bytes each, 2 KB in all. Software fills bytes 4 to 9 of each entry with the attributes of the next frame's sprites. A write to one fixed offset tells the block that the list is complete. The block then copies bytes 4 to 9 of every entry into bytes 10 to 15 of the same entry. The sprite renderer sees only bytes 10 to 15, through a read port of its own.

Because the displayed copy lives in bytes that only the copy engine writes, software can wipe or rewrite the whole area without disturbing the current picture, as long as it does not write the trigger offset. The displayed list is one frame behind the list that software builds.

The copy moves one byte per clock. While it runs, `busy` is high. Ordinary CPU writes wait on `cpuWait` until the copy ends. A trigger write that arrives during a copy is accepted at once and queues one more full pass.

Top module: `sprite_list_buffer`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy` and `cpuWait` are low.
- R2: A CPU write to a byte offset 0 to 9 of any entry is stored when the block is idle. Presenting an address on `cpuAddr` returns that byte on `cpuRdData` one clock later. The entry index is address bits [10:4] and the byte offset is bits [3:0].
- R3: An accepted write to offset 0x7F2 while idle starts a copy. `busy` is high from the next cycle for exactly 768 cycles (128 entries times 6 bytes, one byte per clock).
- R4: After a copy, each entry's active bytes hold the values that its bytes 4 to 9 had when the copy started. Renderer address (`rdEntry`, `rdSel`=k, with k from 0 to 5) returns byte 10+k on `rdData` one clock later. A CPU read at byte offset 10+k returns the same value.
- R5: CPU writes to byte offsets 10 to 15 are discarded. They change neither `rdData` nor `cpuRdData`.
- R6: While `busy` is high, a CPU write to any address other than 0x7F2 raises `cpuWait` and is not performed. It completes in the first cycle that `cpuWait` is low. The copy in progress uses the staged bytes as they were when it started.
- R7: A trigger write during a copy, including one in the final copy cycle, is accepted without wait. It makes one more full copy follow with no idle cycle, so `busy` stays high for 768 more cycles. Several triggers during one copy merge into one extra copy.
- R8: The data of a trigger write is stored at offset 0x7F2 like any other write to byte 2.
- R9: Renderer reads with `rdSel` equal to 6 or 7 return zero.
- R10: Writes to staged bytes without a trigger write leave `rdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 11 | CPU byte address within the sprite area |
| cpuWe | input | 1 | CPU write request, held until `cpuWait` is low |
| cpuWrData | input | 8 | CPU write data |
| cpuWait | output | 1 | CPU write stalled this cycle |
| cpuRdData | output | 8 | Byte at the address presented in the previous cycle |
| busy | output | 1 | Copy in progress |
| rdEntry | input | 7 | Renderer entry index |
| rdSel | input | 3 | Renderer active byte select, 0 to 5 |
| rdData | output | 8 | Renderer active byte, one clock after the address |

## Verification
The hardest case to reach is a trigger that arrives in the last copy cycle. The block must restart with no idle cycle, and that edge exists only once per 768 cycles. The bench counts clock edges from the first accepted trigger and places the second trigger write so that it is accepted on exactly the final copy edge. It also places one at a random point mid-copy, and it checks the total busy length in both cases. A staged write that stalls across a whole copy is also aimed at directly. The bench then checks that the copy took the old byte and that the next copy takes the new one.

// File: rtl/sprbuf_pkg.sv
package sprbuf_pkg;

  typedef struct packed {
    logic cpyEn;    // copy step active this cycle
    logic wrLow;    // accepted CPU write into bytes below the active field
  } sprStrobe_t;

  function automatic int idxW(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sprbuf_ctrl.sv
module sprbuf_ctrl
  import sprbuf_pkg::*;
#(
  parameter int ENTRIES     = 128,
  parameter int ENTRY_BYTES = 16,
  parameter int COPY_LEN    = 6,
  parameter int TRIG_OFFSET = 'h7F2,
  localparam int ADDR_W     = idxW(ENTRIES * ENTRY_BYTES),
  localparam int BYTE_W     = idxW(ENTRY_BYTES),
  localparam int ENT_W      = ADDR_W - BYTE_W,
  localparam int IDX_W      = idxW(COPY_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  output sprStrobe_t        strb,
  output logic [ENT_W-1:0]  cpyEntry,
  output logic [IDX_W-1:0]  cpyIdx,
  output logic              busy,
  output logic              cpuWait
);

  localparam int ACTIVE_FIRST = ENTRY_BYTES - COPY_LEN;

  logic             pending;
  logic             isTrig;
  logic             accept;
  logic             lastStep;
  logic             lastIdx;
  logic [BYTE_W-1:0] byteOff;

  assign byteOff  = cpuAddr[BYTE_W-1:0];
  assign isTrig   = cpuWe && (cpuAddr == ADDR_W'(TRIG_OFFSET));
  assign cpuWait  = cpuWe && busy && !isTrig;
  assign accept   = cpuWe && !cpuWait;
  assign lastIdx  = (cpyIdx == IDX_W'(COPY_LEN - 1));
  assign lastStep = busy && lastIdx && (cpyEntry == ENT_W'(ENTRIES - 1));

  always_comb begin
    strb.cpyEn = busy;
    strb.wrLow = accept && (byteOff < BYTE_W'(ACTIVE_FIRST));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      pending  <= 1'b0;
      cpyEntry <= '0;
      cpyIdx   <= '0;
    end else if (busy) begin
      if (lastStep) begin
        cpyEntry <= '0;
        cpyIdx   <= '0;
        pending  <= 1'b0;
        busy     <= pending || isTrig;
      end else begin
        if (lastIdx) begin
          cpyIdx   <= '0;
          cpyEntry <= cpyEntry + ENT_W'(1);
        end else begin
          cpyIdx <= cpyIdx + IDX_W'(1);
        end
        if (isTrig) pending <= 1'b1;
      end
    end else if (isTrig) begin
      busy     <= 1'b1;
      cpyEntry <= '0;
      cpyIdx   <= '0;
    end
  end

  // R3: an idle trigger starts the walk at entry 0, byte 0
  a_r3_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && isTrig) |=> (busy && cpyEntry == '0 && cpyIdx == '0));

  // R3: the walk advances exactly one byte per clock
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastStep) |=> (busy &&
      ((cpyEntry == $past(cpyEntry) && cpyIdx == $past(cpyIdx) + IDX_W'(1)) ||
       (cpyEntry == $past(cpyEntry) + ENT_W'(1) && cpyIdx == '0))));

  // R7: a queued or same-cycle trigger restarts without an idle cycle
  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    (lastStep && (pending || isTrig)) |=> (busy && cpyEntry == '0 && cpyIdx == '0));

  // R7: a queued trigger only exists during a copy
  a_r7_pending_busy: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> busy);

  // R4: the byte index never leaves the copied field
  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    cpyIdx < IDX_W'(COPY_LEN));

endmodule

// File: rtl/sprbuf_datapath.sv
module sprbuf_datapath
  import sprbuf_pkg::*;
#(
  parameter int ENTRIES     = 128,
  parameter int ENTRY_BYTES = 16,
  parameter int STAGE_FIRST = 4,
  parameter int COPY_LEN    = 6,
  parameter int DATA_W      = 8,
  localparam int ADDR_W     = idxW(ENTRIES * ENTRY_BYTES),
  localparam int BYTE_W     = idxW(ENTRY_BYTES),
  localparam int ENT_W      = ADDR_W - BYTE_W,
  localparam int IDX_W      = idxW(COPY_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sprStrobe_t        strb,
  input  logic [ENT_W-1:0]  cpyEntry,
  input  logic [IDX_W-1:0]  cpyIdx,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic [ENT_W-1:0]  rdEntry,
  input  logic [IDX_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData
);

  localparam int ACTIVE_FIRST = ENTRY_BYTES - COPY_LEN;
  localparam int LO_DEPTH     = ENTRIES * ACTIVE_FIRST;
  localparam int HI_DEPTH     = ENTRIES * COPY_LEN;
  localparam int LO_AW        = idxW(LO_DEPTH);
  localparam int HI_AW        = idxW(HI_DEPTH);

  // staging/low bank: CPU-owned bytes 0..ACTIVE_FIRST-1
  logic [DATA_W-1:0] loMem [LO_DEPTH];
  // active bank: only the copy engine writes it
  logic [DATA_W-1:0] hiMem [HI_DEPTH];

  logic [ENT_W-1:0]  cpuEntry;
  logic [BYTE_W-1:0] cpuByte;
  logic [BYTE_W-1:0] cpuHiByte;
  logic              cpuInLow;
  logic [LO_AW-1:0]  cpuLoIdx;
  logic [HI_AW-1:0]  cpuHiIdx;
  logic [LO_AW-1:0]  srcIdx;
  logic [HI_AW-1:0]  dstIdx;
  logic [HI_AW-1:0]  rdIdx;
  logic              rdValid;

  always_comb begin
    cpuEntry  = cpuAddr[ADDR_W-1:BYTE_W];
    cpuByte   = cpuAddr[BYTE_W-1:0];
    cpuInLow  = cpuByte < BYTE_W'(ACTIVE_FIRST);
    cpuHiByte = cpuByte - BYTE_W'(ACTIVE_FIRST);
    cpuLoIdx  = LO_AW'(cpuEntry) * LO_AW'(ACTIVE_FIRST) + LO_AW'(cpuByte);
    cpuHiIdx  = HI_AW'(cpuEntry) * HI_AW'(COPY_LEN) + HI_AW'(cpuHiByte);
    srcIdx    = LO_AW'(cpyEntry) * LO_AW'(ACTIVE_FIRST) + LO_AW'(STAGE_FIRST) + LO_AW'(cpyIdx);
    dstIdx    = HI_AW'(cpyEntry) * HI_AW'(COPY_LEN) + HI_AW'(cpyIdx);
    rdValid   = rdSel < IDX_W'(COPY_LEN);
    rdIdx     = HI_AW'(rdEntry) * HI_AW'(COPY_LEN) + HI_AW'(rdSel);
  end

  always_ff @(posedge clk) begin
    if (strb.wrLow) loMem[cpuLoIdx] <= cpuWrData;
  end

  always_ff @(posedge clk) begin
    if (strb.cpyEn) hiMem[dstIdx] <= loMem[srcIdx];
  end

  always_ff @(posedge clk) begin
    cpuRdData <= cpuInLow ? loMem[cpuLoIdx] : hiMem[cpuHiIdx];
    rdData    <= rdValid ? hiMem[rdIdx] : '0;
  end

  // R6: no CPU write lands in the staged field while it is being copied
  a_r6_stage_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cpyEn && strb.wrLow) |->
      (cpuByte < BYTE_W'(STAGE_FIRST) || cpuByte >= BYTE_W'(STAGE_FIRST + COPY_LEN)));

  // R9: an out-of-range select reads as zero
  a_r9_sel_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> (rdData == '0));

endmodule

// File: rtl/sprite_list_buffer.sv
module sprite_list_buffer
  import sprbuf_pkg::*;
#(
  parameter int ENTRIES     = 128,
  parameter int ENTRY_BYTES = 16,
  parameter int STAGE_FIRST = 4,
  parameter int COPY_LEN    = 6,
  parameter int DATA_W      = 8,
  parameter int TRIG_OFFSET = 'h7F2,
  localparam int ADDR_W     = idxW(ENTRIES * ENTRY_BYTES),
  localparam int BYTE_W     = idxW(ENTRY_BYTES),
  localparam int ENT_W      = ADDR_W - BYTE_W,
  localparam int IDX_W      = idxW(COPY_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic              cpuWait,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              busy,
  input  logic [ENT_W-1:0]  rdEntry,
  input  logic [IDX_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData
);

  sprStrobe_t       strb;
  logic [ENT_W-1:0] cpyEntry;
  logic [IDX_W-1:0] cpyIdx;

  sprbuf_ctrl #(
    .ENTRIES(ENTRIES), .ENTRY_BYTES(ENTRY_BYTES),
    .COPY_LEN(COPY_LEN), .TRIG_OFFSET(TRIG_OFFSET)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .strb(strb), .cpyEntry(cpyEntry), .cpyIdx(cpyIdx),
    .busy(busy), .cpuWait(cpuWait)
  );

  sprbuf_datapath #(
    .ENTRIES(ENTRIES), .ENTRY_BYTES(ENTRY_BYTES), .STAGE_FIRST(STAGE_FIRST),
    .COPY_LEN(COPY_LEN), .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cpyEntry(cpyEntry), .cpyIdx(cpyIdx),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .rdEntry(rdEntry), .rdSel(rdSel), .rdData(rdData)
  );

  // R1: nothing is busy or stalled coming out of reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!busy && !cpuWait));

endmodule

// File: tb/tb_sprite_list_buffer.sv
`timescale 1ns/1ps
module tb_sprite_list_buffer;

  localparam int ENTRIES = 128;
  localparam int NBYTES  = 16;
  localparam int LOWN    = 10;
  localparam int CLEN    = 6;
  localparam int TRIG    = 'h7F2;
  localparam int COPYCYC = ENTRIES * CLEN;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [10:0] cpuAddr = '0;
  logic       cpuWe = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic       cpuWait;
  logic [7:0] cpuRdData;
  logic       busy;
  logic [6:0] rdEntry = '0;
  logic [2:0] rdSel = '0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mLo [ENTRIES*LOWN];
  int mHi [ENTRIES*CLEN];

  sprite_list_buffer dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuWrData(cpuWrData), .cpuWait(cpuWait), .cpuRdData(cpuRdData),
    .busy(busy), .rdEntry(rdEntry), .rdSel(rdSel), .rdData(rdData)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCpu(input int a);
    int e = a / NBYTES;
    int b = a % NBYTES;
    return (b < LOWN) ? mLo[e*LOWN + b] : mHi[e*CLEN + b - LOWN];
  endfunction

  function automatic int expRend(input int e, input int s);
    return (s < CLEN) ? mHi[e*CLEN + s] : 0;
  endfunction

  task automatic modelCopy();
    for (int e = 0; e < ENTRIES; e++)
      for (int k = 0; k < CLEN; k++)
        mHi[e*CLEN + k] = mLo[e*LOWN + 4 + k];
  endtask

  // returns at posedge+1 of the accepting edge
  task automatic cpuWrite(input int a, input int d, output int stalls);
    stalls = 0;
    @(negedge clk);
    cpuAddr = 11'(a); cpuWrData = 8'(d); cpuWe = 1'b1;
    #1;
    while (cpuWait) begin stalls++; @(negedge clk); #1; end
    @(posedge clk); #1;
    cpuWe = 1'b0;
    if ((a % NBYTES) < LOWN) mLo[(a / NBYTES)*LOWN + (a % NBYTES)] = d & 255;
    if (a == TRIG) modelCopy();
  endtask

  task automatic cpuRead(input int a, input string req);
    @(negedge clk); cpuAddr = 11'(a);
    @(posedge clk); #1;
    check(int'(cpuRdData) == expCpu(a), req, int'(cpuRdData), expCpu(a));
  endtask

  task automatic rendRead(input int e, input int s, input string req);
    @(negedge clk); rdEntry = 7'(e); rdSel = 3'(s);
    @(posedge clk); #1;
    check(int'(rdData) == expRend(e, s), req, int'(rdData), expRend(e, s));
  endtask

  task automatic waitIdle();
    while (busy) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int st, c0, a, d, r, oldv, seedv;
    seedv = $urandom(32'd4711);
    foreach (mLo[i]) mLo[i] = 0;
    foreach (mHi[i]) mHi[i] = 0;

    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(cpuWait == 1'b0, "R1 wait in reset", int'(cpuWait), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check(busy == 1'b0 && cpuWait == 1'b0, "R1 after release", int'(busy), 0);

    // R2 fill whole area (active bytes discarded, see R5)
    for (int i = 0; i < ENTRIES*NBYTES; i++)
      if (i != TRIG) cpuWrite(i, $urandom % 256, st);
    for (int i = 0; i < 64; i++) begin
      a = $urandom % (ENTRIES*NBYTES);
      cpuRead(a, "R2 readback");
    end
    cpuRead(0, "R2 entry 0 byte 0");
    cpuRead(ENTRIES*NBYTES - 7, "R2 last entry byte 9");

    // R10 renderer unchanged before any trigger
    rendRead(5, 2, "R10 no trigger yet");

    // R3 + R8 copy length and trigger data stored
    cpuWrite(TRIG, 8'hA5, st);
    c0 = cyc;
    check(st == 0, "R3 trigger no wait", st, 0);
    check(busy == 1'b1, "R3 busy after trigger", int'(busy), 1);
    waitIdle();
    check(cyc - c0 == COPYCYC, "R3 copy length", cyc - c0, COPYCYC);
    cpuRead(TRIG, "R8 trigger data stored");

    // R4 all active bytes
    for (int e = 0; e < ENTRIES; e++)
      for (int k = 0; k < CLEN; k++) rendRead(e, k, "R4 renderer active byte");
    for (int i = 0; i < 16; i++) begin
      a = ($urandom % ENTRIES) * NBYTES + LOWN + ($urandom % CLEN);
      cpuRead(a, "R4 cpu view of active byte");
    end

    // R9 out-of-range selects
    rendRead(3, 6, "R9 sel 6");
    rendRead(127, 7, "R9 sel 7");

    // R5 / R10 bulk clear without trigger
    for (int i = 0; i < ENTRIES*NBYTES; i++)
      if (i != TRIG) cpuWrite(i, 0, st);
    for (int i = 0; i < 24; i++)
      rendRead($urandom % ENTRIES, $urandom % CLEN, "R10 clear keeps display");
    cpuRead(17*NBYTES + 12, "R5 active write discarded");
    cpuWrite(9*NBYTES + 11, 8'h3C, st);
    cpuRead(9*NBYTES + 11, "R5 cpu view after active write");
    rendRead(9, 1, "R5 renderer after active write");

    // R6 stalled staged write across a whole copy
    cpuWrite(2*NBYTES + 4, 8'h11, st);
    cpuWrite(TRIG, 8'h5A, st);
    oldv = mHi[2*CLEN];
    cpuWrite(2*NBYTES + 4, 8'h77, st);
    check(st == COPYCYC, "R6 stall cycles", st, COPYCYC);
    check(busy == 1'b0, "R6 idle after stall", int'(busy), 0);
    check(mHi[2*CLEN] == oldv, "R6 model sanity", mHi[2*CLEN], oldv);
    rendRead(2, 0, "R6 copy used old staged byte");
    cpuRead(2*NBYTES + 4, "R6 stalled write landed");
    cpuWrite(TRIG, 8'h01, st);
    waitIdle();
    rendRead(2, 0, "R6 next copy takes new byte");

    // R7 trigger on final copy edge
    cpuWrite(TRIG, 8'h21, st);
    c0 = cyc;
    while (cyc < c0 + COPYCYC - 1) begin @(posedge clk); #1; end
    cpuWrite(TRIG, 8'h42, st);
    check(st == 0, "R7 last-edge trigger no wait", st, 0);
    check(cyc - c0 == COPYCYC, "R7 accepted on last edge", cyc - c0, COPYCYC);
    check(busy == 1'b1, "R7 busy continues", int'(busy), 1);
    waitIdle();
    check(cyc - c0 == 2*COPYCYC, "R7 back-to-back length", cyc - c0, 2*COPYCYC);
    cpuRead(TRIG, "R8 second trigger data");

    // R7 two triggers mid-copy merge into one extra pass
    cpuWrite(TRIG, 8'h03, st);
    c0 = cyc;
    r = 50 + ($urandom % 600);
    while (cyc < c0 + r) begin @(posedge clk); #1; end
    cpuWrite(TRIG, 8'h04, st);
    check(st == 0, "R7 mid trigger no wait", st, 0);
    cpuWrite(TRIG, 8'h05, st);
    waitIdle();
    check(cyc - c0 == 2*COPYCYC, "R7 merged length", cyc - c0, 2*COPYCYC);
    rendRead(64, 3, "R7 display after merged copies");

    // random mix
    for (int i = 0; i < 2500; i++) begin
      r = $urandom % 100;
      if (r < 45) begin
        a = $urandom % (ENTRIES*NBYTES);
        if (a == TRIG) a = TRIG - 1;
        d = $urandom % 256;
        cpuWrite(a, d, st);
      end else if (r < 72) begin
        cpuRead($urandom % (ENTRIES*NBYTES), "R2 random cpu read");
      end else if (r < 98) begin
        rendRead($urandom % ENTRIES, $urandom % 8, "R4 random renderer read");
      end else begin
        cpuWrite(TRIG, $urandom % 256, st);
        waitIdle();
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule